// File: doc/BRIEF.md
# Top-of-Stack Operand Address Generator

This block supplies the memory address of an instruction operand that is fetched from or stored to the top of the stack. It also moves the stack pointer as that operand requires. A request carries the operand's size and its access class. The access class alone decides whether the pointer pops, pushes or stays where it is; the opcode plays no part. A read operand takes the current pointer as its address and then pops. A write operand pushes first and uses the lowered pointer. A read-modify-write operand, such as a loop counter kept on the stack, leaves the pointer alone, and so does an address operand such as a jump target.

Each request produces a registered done pulse one cycle later, together with the effective address and the committed pointer. An instruction's two operands are issued one request at a time, in order. The block tracks which operand slot it is serving, so the second operand always sees the pointer as the first operand left it. A synchronous reset loads the pointer from an input that holds the reset value.

Top module: `tos_agen`

## Requirements
- R1: While `rst` is high at a clock edge, `sp_cur` takes the value of `rst_sp`, `done` is 0 and `slot` is 0.
- R2: A request with `acc_class` = 0 (read) gives `ea` equal to the pointer before the request. The pointer then increases by the operand size.
- R3: A request with `acc_class` = 1 (write) first lowers the pointer by the operand size. `ea` equals the lowered pointer.
- R4: A request with `acc_class` = 2 (read-modify-write) gives `ea` equal to the current pointer and leaves the pointer unchanged.
- R5: A request with `acc_class` = 3 (address) gives `ea` equal to the current pointer and leaves the pointer unchanged.
- R6: The pointer step in bytes follows `opnd_size`: 0 steps by 1, 1 steps by 2, and both 2 and 3 step by 4.
- R7: `done` is high in exactly the cycle after each cycle in which `req` is high. Without a request, `done` is 0 and `sp_cur` and `ea` hold their values.
- R8: `slot` toggles with every completed request and starts at 0 after reset. A request issued back to back after another one uses the pointer that the earlier request committed.
- R9: Pointer arithmetic wraps modulo 2^AW in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rst_sp | input | AW | Pointer value loaded on reset |
| req | input | 1 | One operand address request |
| opnd_size | input | 2 | Operand size code: 0 byte, 1 word, 2 or 3 double word |
| acc_class | input | 2 | Access class: 0 read, 1 write, 2 read-modify-write, 3 address |
| ea | output | AW | Effective address of the last completed request |
| sp_cur | output | AW | Committed stack pointer |
| done | output | 1 | One-cycle pulse for a completed request |
| slot | output | 1 | Operand slot of the next request (0 first, 1 second) |

## Verification
Two cases are the hardest to reach from the ports. The first is a pair of requests in consecutive cycles, where the second request must use a pointer committed at the same edge as the first request's done pulse. The second is a pointer that wraps at either end of the address space. The stimulus issues read-then-read-modify-write pairs with no gap between them and mixes pushes and pops in random runs. It also resets the pointer near zero and near the all-ones value so that pushes and pops cross the wrap point.

// File: rtl/tos_agen_pkg.sv
package tos_agen_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RMW   = 2'd2,
    ACC_ADDR  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

  // Byte count of an operand; the reserved code is treated as double word.
  function automatic logic [2:0] size_bytes(input size_e s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic moves_up(input acc_e c);
    moves_up = (c == ACC_READ);
  endfunction

  function automatic logic moves_down(input acc_e c);
    moves_down = (c == ACC_WRITE);
  endfunction

endpackage

// File: rtl/tos_step_calc.sv
module tos_step_calc
  import tos_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] sp_in,
  input  size_e         size,
  input  acc_e          cls,
  output logic [AW-1:0] ea_out,
  output logic [AW-1:0] sp_out,
  output logic          pops,
  output logic          pushes
);
  logic [AW-1:0] step;

  always_comb begin
    step   = AW'(size_bytes(size));
    pops   = moves_up(cls);
    pushes = moves_down(cls);
    sp_out = sp_in;
    ea_out = sp_in;
    if (pops) begin
      sp_out = sp_in + step;
    end else if (pushes) begin
      sp_out = sp_in - step;
      ea_out = sp_in - step;
    end
  end
endmodule

// File: rtl/tos_slot_seq.sv
module tos_slot_seq (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic slot
);
  always_ff @(posedge clk) begin
    if (rst)      slot <= 1'b0;
    else if (adv) slot <= ~slot;
  end
endmodule

// File: rtl/tos_agen.sv
module tos_agen
  import tos_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rst_sp,
  input  logic          req,
  input  logic [1:0]    opnd_size,
  input  logic [1:0]    acc_class,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] sp_cur,
  output logic          done,
  output logic          slot
);
  logic [AW-1:0] sp_q, ea_q, ea_calc, sp_calc;
  logic          done_q;
  logic          ev_pop, ev_push, ev_commit;

  assign ev_commit = req;

  tos_step_calc #(.AW(AW)) u_calc (
    .sp_in  (sp_q),
    .size   (size_e'(opnd_size)),
    .cls    (acc_e'(acc_class)),
    .ea_out (ea_calc),
    .sp_out (sp_calc),
    .pops   (ev_pop),
    .pushes (ev_push)
  );

  tos_slot_seq u_slot (
    .clk  (clk),
    .rst  (rst),
    .adv  (ev_commit),
    .slot (slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= rst_sp;
      ea_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= ev_commit;
      if (ev_commit) begin
        sp_q <= sp_calc;
        ea_q <= ea_calc;
      end
    end
  end

  assign ea     = ea_q;
  assign sp_cur = sp_q;
  assign done   = done_q;
endmodule

// File: rtl/tos_agen_chk.sv
module tos_agen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic [1:0]    acc_class,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] sp_cur,
  input logic          done,
  input logic          slot,
  input logic          ev_pop,
  input logic          ev_push
);
  // R7
  done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> done);
  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!done && $stable(sp_cur) && $stable(ea)));
  // R4
  rmw_keeps_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (req && acc_class == 2'd2) |=> (sp_cur == $past(sp_cur)));
  // R5
  addr_keeps_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (req && acc_class == 2'd3) |=> (ea == $past(sp_cur) && sp_cur == $past(sp_cur)));
  // R2
  read_ea_chk: assert property (@(posedge clk) disable iff (rst)
    (req && acc_class == 2'd0) |=> (ea == $past(sp_cur)));
  // R3
  write_ea_chk: assert property (@(posedge clk) disable iff (rst)
    (req && acc_class == 2'd1) |=> (ea == sp_cur));
  // R8
  slot_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> (slot != $past(slot)));
  // R2 R3
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(ev_pop && ev_push));
endmodule

bind tos_agen tos_agen_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .acc_class (acc_class),
  .ea        (ea),
  .sp_cur    (sp_cur),
  .done      (done),
  .slot      (slot),
  .ev_pop    (ev_pop),
  .ev_push   (ev_push)
);

// File: tb/tos_agen_bench.sv
module tos_agen_bench;
  localparam int AW = 32;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] rst_sp;
  logic          req;
  logic [1:0]    opnd_size;
  logic [1:0]    acc_class;
  logic [AW-1:0] ea, sp_cur;
  logic          done, slot;

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] m_sp, m_ea;
  logic          m_done, m_slot;

  always #(PERIOD/2) clk = ~clk;

  tos_agen #(.AW(AW)) u_tos_agen (
    .clk(clk), .rst(rst), .rst_sp(rst_sp), .req(req),
    .opnd_size(opnd_size), .acc_class(acc_class),
    .ea(ea), .sp_cur(sp_cur), .done(done), .slot(slot)
  );

  function automatic string cls_tag(input logic [1:0] c);
    case (c)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "ea", ea, m_ea);
    chk(tag, "sp_cur", sp_cur, m_sp);
    chk("R7", "done", AW'(done), AW'(m_done));
    chk("R8", "slot", AW'(slot), AW'(m_slot));
  endtask

  // One clock: drive at the negedge, advance the model, compare at the next negedge.
  task automatic step(input logic r, input logic [1:0] sz, input logic [1:0] cl,
                      input string tag);
    int nbytes;
    req = r; opnd_size = sz; acc_class = cl;
    nbytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;   // R6
    if (r) begin
      if (cl == 2'd0) begin m_ea = m_sp; m_sp = m_sp + AW'(nbytes); end
      else if (cl == 2'd1) begin m_sp = m_sp - AW'(nbytes); m_ea = m_sp; end
      else m_ea = m_sp;
      m_slot = ~m_slot;
    end
    m_done = r;
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input logic [AW-1:0] v);
    rst = 1'b1; rst_sp = v; req = 1'b0;
    @(posedge clk); @(negedge clk);
    m_sp = v; m_ea = '0; m_done = 1'b0; m_slot = 1'b0;
    compare("R1");
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; rst_sp = 32'h0000_1000; req = 1'b0; opnd_size = 2'd0; acc_class = 2'd0;
    @(negedge clk);
    do_reset(32'h0000_1000);
    // R2 R6 pop each size
    step(1, 2'd2, 2'd0, "R2");
    step(1, 2'd1, 2'd0, "R6");
    step(1, 2'd0, 2'd0, "R6");
    step(1, 2'd3, 2'd0, "R6");
    // R7 idle
    step(0, 2'd2, 2'd1, "R7");
    step(0, 2'd0, 2'd0, "R7");
    // R3 push
    step(1, 2'd0, 2'd1, "R3");
    step(1, 2'd2, 2'd1, "R3");
    // R4 R5
    step(1, 2'd2, 2'd2, "R4");
    step(1, 2'd1, 2'd3, "R5");
    // R8 read then rmw back to back
    step(1, 2'd2, 2'd0, "R8");
    step(1, 2'd2, 2'd2, "R8");
    step(0, 2'd0, 2'd0, "R8");
    // R9 wrap below zero and above max
    do_reset(32'h0000_0001);
    step(1, 2'd2, 2'd1, "R9");
    step(1, 2'd2, 2'd0, "R9");
    do_reset(32'hFFFF_FFFE);
    step(1, 2'd2, 2'd0, "R9");
    step(1, 2'd1, 2'd1, "R9");
    // R1 reset while busy
    step(1, 2'd0, 2'd1, "R3");
    do_reset(32'h0000_8000);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic r;
      logic [1:0] s, c;
      r = ($urandom % 4) != 0;
      s = 2'($urandom);
      c = 2'($urandom);
      step(r, s, c, cls_tag(c));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule